// File: doc/BRIEF.md
# CAVLC Level Decoder

This block turns the level part of one CAVLC residual block into signed coefficient values. A start strobe in the idle state captures the block's total coefficient count and its trailing-ones count, both decoded elsewhere. From the next cycle the block looks at a left-aligned bitstream window, most significant bit first. Each cycle it produces one value and reports how many window bits that value used.

The upstream bit buffer must apply that count before the next cycle, so the window always begins at the next unread bit. The trailing-one signs come out first, one bit per value. After them the block parses the remaining levels as a prefix, found by leading-one detection, and a variable-size suffix. It uses the adaptive suffix length and the two size exceptions for long prefixes. After the last value it pulses done. Token, total-zeros and run lookups, buffering and coefficient reordering are done by neighbouring blocks.

Top module: `cavlc_level_dec`

## Requirements
- R1: A start strobe is accepted only while idle and captures total_coeff_i and trailing_ones_i. With a total of 0, done_o is high in the next cycle and no value is emitted.
- R2: The first trailing_ones_i values are trailing-one signs. A window MSB of 1 gives -1 and a window MSB of 0 gives +1. Each sign value has adv_o = 1.
- R3: For a level, the prefix is the number of 0 bits before the first 1 in the window. adv_o equals prefix + 1 + suffix size, and the suffix is the suffix-size bits that follow the 1. Prefixes above 15 are outside the supported range.
- R4: The suffix length starts at 1 when the total is above 10 and trailing ones are below 3. In every other case it starts at 0.
- R5: The suffix size equals the suffix length, with two exceptions. A prefix of 14 with a suffix length of 0 gives size 4. A prefix of 15 gives size 12. Size 0 gives a suffix of 0.
- R6: The level code is (prefix << suffix length) + suffix. It gains 15 more when the prefix is 15 and the suffix length is 0. The first non-sign level gains 2 more when trailing ones are below 3.
- R7: An even level code c gives the value (c+2)/2. An odd level code gives -(c+1)/2.
- R8: After each level, a suffix length of 0 becomes 1. The suffix length then grows by one when |value| > 3 << (length-1), and it never exceeds 6.
- R9: lvl_last_o is high with the value whose index is total-1. done_o is high for the one following cycle, and lvl_valid_o is then low.
- R10: While idle, lvl_valid_o, lvl_last_o and adv_o are 0 whatever the window holds. Reset leaves the block idle with done_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a block (sampled while idle) |
| total_coeff_i | input | 5 | Number of nonzero coefficients, 0..16 |
| trailing_ones_i | input | 2 | Number of trailing ±1 coefficients, 0..3 |
| win_i | input | WIN_W | Bitstream window, next unread bit at the MSB |
| lvl_valid_o | output | 1 | lvl_o carries a value this cycle |
| lvl_o | output | LVL_W | Signed coefficient value |
| lvl_last_o | output | 1 | Final value of the block |
| adv_o | output | 6 | Bits consumed from the window this cycle |
| done_o | output | 1 | One-cycle pulse after the final value |

## Verification
The block's state is the phase, the value index and the running suffix length. A suffix length that is wrong by one shows up as a wrong adv_o on the very next level. The bit buffer then goes out of step, so every later value in the block is also wrong. A wrong index or phase shows up as a sign value that is not ±1, or as lvl_last_o and done_o arriving a cycle early or late. The directed blocks are built so that each rule changes the bit count of the step where it applies. Each fault therefore becomes visible at the ports in the same cycle.

// File: rtl/cavlc_lvl_pkg.sv
package cavlc_lvl_pkg;

    // Processing phase of the level decoder.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SIGN  = 2'd1,
        ST_LEVEL = 2'd2
    } lvl_phase_e;

    localparam int PFX_W    = 4;   // prefix range 0..15
    localparam int PFX_SCAN = 16;  // bits scanned for the leading one
    localparam int SFX_MAX  = 12;  // widest suffix
    localparam int SL_W     = 3;   // suffix length 0..6
    localparam int SL_MAX   = 6;
    localparam int LC_W     = 14;  // level code width
    localparam int ADV_W    = 6;

endpackage

// File: rtl/cavlc_lvl_lod.sv
module cavlc_lvl_lod #(
    parameter int SCAN_W = 16,
    parameter int OUT_W  = 4
) (
    input  logic [SCAN_W-1:0] bits_i,
    output logic [OUT_W-1:0]  zeros_o
);
    // Upward scan: the highest set bit is visited last and wins.
    always_comb begin
        zeros_o = OUT_W'(SCAN_W - 1);
        for (int i = 0; i < SCAN_W; i++) begin
            if (bits_i[i]) begin
                zeros_o = OUT_W'(SCAN_W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/cavlc_lvl_calc.sv
module cavlc_lvl_calc
    import cavlc_lvl_pkg::*;
#(
    parameter int WIN_W = 32,
    parameter int LVL_W = 16
) (
    input  logic [WIN_W-1:0]        win_i,
    input  logic [SL_W-1:0]         sl_i,
    input  logic                    bonus_i,
    output logic signed [LVL_W-1:0] level_o,
    output logic [ADV_W-1:0]        adv_o,
    output logic [SL_W-1:0]         sl_next_o
);
    logic [PFX_W-1:0] pfx;
    logic [3:0]       sfx_size;
    logic [WIN_W-1:0] after_one;
    logic [SFX_MAX-1:0] sfx;
    logic [LC_W-1:0]  lcode;
    logic [LVL_W-1:0] mag;
    logic [SL_W-1:0]  sl_base;
    logic [7:0]       thresh;

    cavlc_lvl_lod #(.SCAN_W(PFX_SCAN), .OUT_W(PFX_W)) lod_i (
        .bits_i  (win_i[WIN_W-1 -: PFX_SCAN]),
        .zeros_o (pfx)
    );

    always_comb begin
        // suffix size with the long-prefix exceptions
        if (pfx == 4'd15) begin
            sfx_size = 4'd12;
        end else if (pfx == 4'd14 && sl_i == '0) begin
            sfx_size = 4'd4;
        end else begin
            sfx_size = 4'(sl_i);
        end

        after_one = win_i << ({1'b0, pfx} + 5'd1);
        sfx       = after_one[WIN_W-1 -: SFX_MAX] >> (4'd12 - sfx_size);

        lcode = (LC_W'(pfx) << sl_i) + LC_W'(sfx);
        if (pfx == 4'd15 && sl_i == '0) begin
            lcode = lcode + LC_W'(15);
        end
        if (bonus_i) begin
            lcode = lcode + LC_W'(2);
        end

        // both parities share magnitude (code>>1)+1; bit 0 is the sign
        mag     = LVL_W'(lcode >> 1) + LVL_W'(1);
        level_o = lcode[0] ? -$signed(mag) : $signed(mag);
        adv_o   = ADV_W'(pfx) + ADV_W'(1) + ADV_W'(sfx_size);

        sl_base = (sl_i == '0) ? SL_W'(1) : sl_i;
        thresh  = 8'd3 << (sl_base - SL_W'(1));
        if (mag > LVL_W'(thresh) && sl_base < SL_W'(SL_MAX)) begin
            sl_next_o = sl_base + SL_W'(1);
        end else begin
            sl_next_o = sl_base;
        end
    end
endmodule

// File: rtl/cavlc_level_dec.sv
module cavlc_level_dec
    import cavlc_lvl_pkg::*;
#(
    parameter int WIN_W = 32,
    parameter int LVL_W = 16,
    parameter int CNT_W = 5
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    start_i,
    input  logic [CNT_W-1:0]        total_coeff_i,
    input  logic [1:0]              trailing_ones_i,
    input  logic [WIN_W-1:0]        win_i,
    output logic                    lvl_valid_o,
    output logic signed [LVL_W-1:0] lvl_o,
    output logic                    lvl_last_o,
    output logic [ADV_W-1:0]        adv_o,
    output logic                    done_o
);
    localparam int BIG_TC = 10;

    typedef struct packed {
        lvl_phase_e      st;
        logic [CNT_W-1:0] tc;
        logic [1:0]       t1;
        logic [CNT_W-1:0] idx;
        logic [SL_W-1:0]  sl;
        logic             done;
    } dec_state_t;

    dec_state_t state_d, state_q;

    logic                    is_last;
    logic                    bonus;
    logic signed [LVL_W-1:0] calc_level;
    logic [ADV_W-1:0]        calc_adv;
    logic [SL_W-1:0]         calc_sl;

    assign is_last = (state_q.idx == state_q.tc - CNT_W'(1));
    assign bonus   = (state_q.idx == CNT_W'(state_q.t1)) && (state_q.t1 != 2'd3);

    cavlc_lvl_calc #(.WIN_W(WIN_W), .LVL_W(LVL_W)) calc_i (
        .win_i     (win_i),
        .sl_i      (state_q.sl),
        .bonus_i   (bonus),
        .level_o   (calc_level),
        .adv_o     (calc_adv),
        .sl_next_o (calc_sl)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        lvl_valid_o  = 1'b0;
        lvl_o        = '0;
        lvl_last_o   = 1'b0;
        adv_o        = '0;
        unique case (state_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    state_d.tc  = total_coeff_i;
                    state_d.t1  = trailing_ones_i;
                    state_d.idx = '0;
                    state_d.sl  = (total_coeff_i > CNT_W'(BIG_TC) && trailing_ones_i != 2'd3)
                                  ? SL_W'(1) : SL_W'(0);
                    if (total_coeff_i == '0) begin
                        state_d.done = 1'b1;
                    end else if (trailing_ones_i != 2'd0) begin
                        state_d.st = ST_SIGN;
                    end else begin
                        state_d.st = ST_LEVEL;
                    end
                end
            end
            ST_SIGN: begin
                lvl_valid_o = 1'b1;
                lvl_last_o  = is_last;
                lvl_o       = win_i[WIN_W-1] ? -LVL_W'(1) : LVL_W'(1);
                adv_o       = ADV_W'(1);
                state_d.idx = state_q.idx + CNT_W'(1);
                if (is_last) begin
                    state_d.st   = ST_IDLE;
                    state_d.done = 1'b1;
                end else if (state_d.idx == CNT_W'(state_q.t1)) begin
                    state_d.st = ST_LEVEL;
                end
            end
            ST_LEVEL: begin
                lvl_valid_o = 1'b1;
                lvl_last_o  = is_last;
                lvl_o       = calc_level;
                adv_o       = calc_adv;
                state_d.idx = state_q.idx + CNT_W'(1);
                state_d.sl  = calc_sl;
                if (is_last) begin
                    state_d.st   = ST_IDLE;
                    state_d.done = 1'b1;
                end
            end
            default: state_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{st: ST_IDLE, tc: '0, t1: '0, idx: '0, sl: '0, done: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign done_o = state_q.done;
endmodule

// File: rtl/cavlc_level_dec_chk.sv
module cavlc_level_dec_chk
    import cavlc_lvl_pkg::*;
#(
    parameter int LVL_W = 16
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    lvl_valid_o,
    input logic signed [LVL_W-1:0] lvl_o,
    input logic                    lvl_last_o,
    input logic [ADV_W-1:0]        adv_o,
    input logic                    done_o,
    input lvl_phase_e              st_i,
    input logic [SL_W-1:0]         sl_i
);
    // R2: sign steps consume one bit and yield a unit magnitude
    a_r2_sign_unit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == ST_SIGN) |-> (adv_o == ADV_W'(1) &&
                               (lvl_o == LVL_W'(1) || lvl_o == -LVL_W'(1))));

    // R3: a step never consumes more than prefix 15 + one + 12 suffix bits
    a_r3_adv_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvl_valid_o |-> (adv_o >= ADV_W'(1) && adv_o <= ADV_W'(28)));

    // R7: every emitted value is nonzero
    a_r7_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvl_valid_o |-> (lvl_o != '0));

    // R8: suffix length stays within its cap
    a_r8_sl_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sl_i <= SL_W'(SL_MAX));

    // R8: suffix length never shrinks while levels are being parsed
    a_r8_sl_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == ST_LEVEL && $past(st_i) == ST_LEVEL) |-> (sl_i >= $past(sl_i)));

    // R9: the final value is followed by a done pulse with no value
    a_r9_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lvl_valid_o && lvl_last_o) |=> (done_o && !lvl_valid_o));

    // R10: nothing is consumed or flagged without a valid value
    a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lvl_valid_o |-> (adv_o == '0 && !lvl_last_o));
endmodule

bind cavlc_level_dec cavlc_level_dec_chk #(.LVL_W(LVL_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lvl_valid_o (lvl_valid_o),
    .lvl_o       (lvl_o),
    .lvl_last_o  (lvl_last_o),
    .adv_o       (adv_o),
    .done_o      (done_o),
    .st_i        (state_q.st),
    .sl_i        (state_q.sl)
);

// File: tb/cavlc_level_dec_tb_top.sv
`timescale 1ns/1ps
module cavlc_level_dec_tb_top;
    localparam int WIN_W = 32;
    localparam int LVL_W = 16;
    localparam int ROW_W = 63;
    localparam int NROWS = 34;
    localparam int WATCHDOG_CYC = 20000;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start = 1'b0;
    logic [4:0]              tc = '0;
    logic [1:0]              t1 = '0;
    logic [WIN_W-1:0]        win = '0;
    logic                    vld;
    logic signed [LVL_W-1:0] lvl;
    logic                    last;
    logic [5:0]              adv;
    logic                    done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    cavlc_level_dec #(.WIN_W(WIN_W), .LVL_W(LVL_W), .CNT_W(5)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .total_coeff_i(tc), .trailing_ones_i(t1), .win_i(win),
        .lvl_valid_o(vld), .lvl_o(lvl), .lvl_last_o(last),
        .adv_o(adv), .done_o(done)
    );

    // row: {start, tc, t1, window, value, adv, last}
    function automatic logic [ROW_W-1:0] mk(input bit s, input int c, input int o,
                                             input logic [31:0] w, input int v,
                                             input int a, input bit l);
        return {s, 5'(c), 2'(o), w, 16'(v), 6'(a), l};
    endfunction

    localparam logic [ROW_W-1:0] VEC [NROWS] = '{
        // tc=3 t1=2: two signs, then first level with +2 bonus (R2, R6)
        mk(1, 3, 2, 32'h8000_0000,  -1,  1, 0),
        mk(0, 3, 2, 32'h0000_0000,   1,  1, 0),
        mk(0, 3, 2, 32'h8000_0000,   2,  1, 1),
        // tc=4 t1=0, suffix length from 0 grows to 2 (R4 R8 R3 R7)
        mk(1, 4, 0, 32'h4000_0000,  -2,  2, 0),
        mk(0, 4, 0, 32'h1800_0000,  -4,  5, 0),
        mk(0, 4, 0, 32'hC000_0000,   2,  3, 0),
        mk(0, 4, 0, 32'h2800_0000,  -5,  5, 1),
        // tc=11 t1=1: suffix length starts at 1 (R4)
        mk(1, 11, 1, 32'h0000_0000,  1,  1, 0),
        mk(0, 11, 1, 32'h8000_0000,  2,  2, 0),
        mk(0, 11, 1, 32'hC000_0000, -1,  2, 0),
        mk(0, 11, 1, 32'h8000_0000,  1,  2, 0),
        mk(0, 11, 1, 32'hC000_0000, -1,  2, 0),
        mk(0, 11, 1, 32'h8000_0000,  1,  2, 0),
        mk(0, 11, 1, 32'hC000_0000, -1,  2, 0),
        mk(0, 11, 1, 32'h8000_0000,  1,  2, 0),
        mk(0, 11, 1, 32'hC000_0000, -1,  2, 0),
        mk(0, 11, 1, 32'h8000_0000,  1,  2, 0),
        mk(0, 11, 1, 32'hC000_0000, -1,  2, 1),
        // tc=4 t1=3: no bonus on first level (R6)
        mk(1, 4, 3, 32'h8000_0000,  -1,  1, 0),
        mk(0, 4, 3, 32'h8000_0000,  -1,  1, 0),
        mk(0, 4, 3, 32'h0000_0000,   1,  1, 0),
        mk(0, 4, 3, 32'h8000_0000,   1,  1, 1),
        // prefix 14 at length 0 -> 4-bit suffix; prefix 15 -> 12-bit (R5)
        mk(1, 2, 0, 32'h0002_A000, -11, 19, 0),
        mk(0, 2, 0, 32'h0001_8000, 1055, 28, 1),
        // prefix 15 at length 0 adds 15 (R5 R6)
        mk(1, 1, 0, 32'h0001_0030, -18, 28, 1),
        // prefix 14 at length 1 is not an exception (R5)
        mk(1, 2, 0, 32'h8000_0000,   2,  1, 0),
        mk(0, 2, 0, 32'h0003_0000, -15, 16, 1),
        // suffix length climbs to 6 and stops (R8)
        mk(1, 7, 0, 32'h0001_0000,  17, 28, 0),
        mk(0, 7, 0, 32'h0001_0000,  31, 28, 0),
        mk(0, 7, 0, 32'h0001_0000,  61, 28, 0),
        mk(0, 7, 0, 32'h0001_0000, 121, 28, 0),
        mk(0, 7, 0, 32'h0001_0000, 241, 28, 0),
        mk(0, 7, 0, 32'h0001_0000, 481, 28, 0),
        mk(0, 7, 0, 32'h8A00_0000,  -3,  7, 1)
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        #(WATCHDOG_CYC * 4);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "watchdog", "cycles", WATCHDOG_CYC, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int sign_left;
        // R10: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(!vld && !done && adv == 0, "R10", "reset valid/done/adv",
              {vld, done, adv}, 0);
        @(posedge clk); #1 rst_n = 1'b1; win = '1;
        // R10: idle ignores the window
        @(negedge clk);
        check(!vld && adv == 0 && !last, "R10", "idle adv with full window", adv, 0);

        // R1: empty block
        @(posedge clk); #1 start = 1'b1; tc = 5'd0; t1 = 2'd0;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        check(done && !vld, "R1", "done for zero coefficients", {done, vld}, 2);
        @(negedge clk);
        check(!done && !vld, "R1", "single done pulse", {done, vld}, 0);

        sign_left = 0;
        for (int r = 0; r < NROWS; r++) begin
            logic [ROW_W-1:0] row;
            string tag;
            row = VEC[r];
            if (row[62]) begin
                @(posedge clk); #1 start = 1'b1; tc = row[61:57]; t1 = row[56:55];
                sign_left = int'(row[56:55]);
                @(posedge clk); #1 start = 1'b0; win = row[54:23];
            end else begin
                @(posedge clk); #1 win = row[54:23];
            end
            tag = (sign_left > 0) ? "R2 sign" : "R3 R6 R7 level";
            if (sign_left > 0) sign_left--;
            @(negedge clk);
            check(vld, tag, "valid", vld, 1);
            check(lvl == $signed(row[22:7]), tag, "value", lvl, $signed(row[22:7]));
            check(adv == row[6:1], tag, "advance", adv, row[6:1]);
            check(last == row[0], "R9", "last flag", last, row[0]);
            if (row[0]) begin
                @(posedge clk); #1 win = '1;
                @(negedge clk);
                check(done && !vld && adv == 0, "R9", "done after last",
                      {done, vld}, 2);
            end
        end

        // R1: start while busy is not taken as a new block
        @(posedge clk); #1 start = 1'b1; tc = 5'd2; t1 = 2'd0;
        @(posedge clk); #1 tc = 5'd0; win = 32'h8000_0000;  // start held high
        @(negedge clk);
        check(vld && !last && lvl == 2, "R1", "busy start ignored, first value", lvl, 2);
        @(posedge clk); #1 start = 1'b0; win = 32'h8000_0000;
        @(negedge clk);
        check(vld && last && lvl == 1, "R1", "second value still emitted", lvl, 1);

        repeat (3) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule